// File: doc/BRIEF.md
# Per-core countdown timer

A 32-bit down-counting timer of the kind that sits beside each processor core. Software reaches it through a word-wide register bus with a byte address, a write strobe, write data and combinational read data. It holds a reload value, a live counter, a control word and a sticky expiry flag. The expiry flag, gated by an interrupt-enable bit, drives a level interrupt line.

The counter steps down once every P+1 clock cycles, where P is an 8-bit prescale field in the control word. The timer can run one-shot, stopping at zero, or auto-reload, refilling from the reload value. Writing zero to the reload or counter register either stops the timer quietly or keeps it firing each period. Which one happens depends on whether P is zero, and these rules are followed exactly. A cycle carrying a bus write has no timer step, so every write acts on a settled state.

Top module: `core_down_timer`

## Requirements
- R1: Byte offsets decode as 0x0 reload value, 0x4 live counter, 0x8 control, 0xC status (bit 0). Any other offset reads as zero, and writing it changes nothing.
- R2: Control bit 0 is enable, bit 1 selects auto-reload (1) or one-shot (0), bit 2 is interrupt enable, and bits 15:8 are the prescale P. All other control bits read back as zero.
- R3: While running, the counter drops by one every P+1 clock cycles, and the first drop comes P+1 cycles after the write that started it. A cycle with any bus write moves neither the divider nor the counter, and a stopped timer holds its counter.
- R4: Expiry sets the status bit. The interrupt output is high exactly when status is set and interrupt enable is 1.
- R5: A status write clears the flag where data bit 0 is 1 and leaves it alone where bit 0 is 0. The interrupt output follows in the next cycle.
- R6: A step from 1 to 0 is an expiry. In one-shot mode the counter then stays at 0 and the timer stops. In auto-reload mode the next step loads the reload value. If the reload value is 0, that step is also an expiry.
- R7: A reload write sets both the reload value and the counter. When enabled, the timer runs (restarting the divider) if P or the value is nonzero. With P = 0 and a value of 0, it stops without setting status.
- R8: A counter write of 0 while enabled with P = 0 behaves as follows. In auto-reload mode it is replaced by the reload value. If the timer is one-shot, or the reload value is 0, the timer stops without setting status.
- R9: In auto-reload mode with a reload value of 0, a nonzero P raises an expiry every P+1 cycles. P = 0 stops the timer after one expiry.
- R10: A control write that changes bits 1:0 stops the timer first. If the new word enables it, counting resumes from the current counter. In auto-reload mode with new P = 0, a counter of 0 is first refilled from the reload value. The timer runs if P or that value is nonzero.
- R11: Reset clears reload, counter, control and status, and leaves the timer stopped and the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default widths: a 32-bit counter, an 8-bit prescale and an 8-bit address. This lets it reach the largest prescale of 255 within a few hundred cycles and probe unused offsets above 0xC. A behavioural model runs beside the block and is compared on every cycle through the read port and the interrupt pin. Directed sequences drive each zero-value corner with P both zero and nonzero.

// File: rtl/core_down_timer.sv
module core_down_timer #(
  parameter int DW = 32,
  parameter int PW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_RELOAD = AW'(0);
  localparam logic [AW-1:0] OFS_COUNT  = AW'(4);
  localparam logic [AW-1:0] OFS_CTRL   = AW'(8);
  localparam logic [AW-1:0] OFS_FLAG   = AW'(12);
  localparam int PLO = 8;

  logic [DW-1:0] reload_q, count_q, reload_n, count_n;
  logic          en_q, auto_q, ie_q, en_n, auto_n, ie_n;
  logic [PW-1:0] pre_q, pre_n, div_q, div_n;
  logic          flag_q, flag_n, run_q, run_n, restart;

  wire wr_reload = bus_we && bus_addr == OFS_RELOAD;
  wire wr_count  = bus_we && bus_addr == OFS_COUNT;
  wire wr_ctrl   = bus_we && bus_addr == OFS_CTRL;
  wire wr_flag   = bus_we && bus_addr == OFS_FLAG;
  wire step      = run_q && !bus_we && div_q == pre_q;

  wire [PW-1:0] c_pre     = bus_wdata[PLO +: PW];
  wire          mode_chg  = bus_wdata[1:0] != {auto_q, en_q};
  wire [DW-1:0] c_count   = (bus_wdata[1] && c_pre == '0 && count_q == '0) ? reload_q : count_q;
  wire [DW-1:0] w_count   = (en_q && auto_q && pre_q == '0 && bus_wdata == '0) ? reload_q : bus_wdata;

  always_comb begin
    reload_n = reload_q;
    count_n  = count_q;
    flag_n   = flag_q;
    run_n    = run_q;
    en_n     = en_q;
    auto_n   = auto_q;
    ie_n     = ie_q;
    pre_n    = pre_q;
    restart  = 1'b0;
    div_n    = div_q;
    if (run_q && !bus_we) div_n = step ? '0 : div_q + PW'(1);
    if (wr_reload) begin
      reload_n = bus_wdata;
      count_n  = bus_wdata;
      if (en_q) begin
        run_n   = pre_q != '0 || bus_wdata != '0;
        restart = run_n;
      end
    end else if (wr_count) begin
      count_n = w_count;
      if (en_q) begin
        run_n   = pre_q != '0 || w_count != '0;
        restart = run_n;
      end
    end else if (wr_ctrl) begin
      en_n   = bus_wdata[0];
      auto_n = bus_wdata[1];
      ie_n   = bus_wdata[2];
      pre_n  = c_pre;
      if (bus_wdata[0]) count_n = c_count;
      run_n   = (mode_chg ? 1'b0 : run_q) | (bus_wdata[0] && (c_pre != '0 || c_count != '0));
      restart = run_n && (!run_q || mode_chg || c_pre != pre_q);
    end else if (wr_flag) begin
      flag_n = flag_q & ~bus_wdata[0];
    end else if (step) begin
      if (count_q == '0) begin
        if (auto_q) begin
          count_n = reload_q;
          if (reload_q == '0) begin
            flag_n = 1'b1;
            if (pre_q == '0) run_n = 1'b0;
          end
        end else begin
          flag_n = 1'b1;
          run_n  = 1'b0;
        end
      end else begin
        count_n = count_q - DW'(1);
        if (count_q == DW'(1)) begin
          flag_n = 1'b1;
          if (!auto_q) run_n = 1'b0;
        end
      end
    end
    if (restart) div_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      flag_q   <= 1'b0;
      run_q    <= 1'b0;
      en_q     <= 1'b0;
      auto_q   <= 1'b0;
      ie_q     <= 1'b0;
      pre_q    <= '0;
      div_q    <= '0;
    end else begin
      reload_q <= reload_n;
      count_q  <= count_n;
      flag_q   <= flag_n;
      run_q    <= run_n;
      en_q     <= en_n;
      auto_q   <= auto_n;
      ie_q     <= ie_n;
      pre_q    <= pre_n;
      div_q    <= div_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_RELOAD: bus_rdata = reload_q;
      OFS_COUNT:  bus_rdata = count_q;
      OFS_CTRL: begin
        bus_rdata[0] = en_q;
        bus_rdata[1] = auto_q;
        bus_rdata[2] = ie_q;
        bus_rdata[PLO +: PW] = pre_q;
      end
      OFS_FLAG:   bus_rdata[0] = flag_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & ie_q;

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !bus_we |=> $stable(count_q));
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && !auto_q && count_q == DW'(1) |=> !run_q && count_q == '0 && flag_q);
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag && bus_wdata[0] |=> !flag_q && !irq);
  assert_reload_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> reload_q == $past(bus_wdata) && count_q == $past(bus_wdata));
  assert_zero_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload && en_q && pre_q == '0 && bus_wdata == '0 |=> !run_q && $stable(flag_q));
  assert_mode_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && mode_chg && !bus_wdata[0] |=> !run_q);
endmodule

// File: tb/core_down_timer_test.sv
`timescale 1ns/1ps
module core_down_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'd4;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  core_down_timer uut (.clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
                       .bus_wdata(wd), .bus_rdata(rd), .irq(irq));

  logic [31:0] m_load, m_cnt, v;
  logic [7:0]  m_p, m_div, np;
  bit m_en, m_per, m_ie, m_st, m_run, chg, was;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_load = 0; m_cnt = 0; m_p = 0; m_div = 0;
      m_en = 0; m_per = 0; m_ie = 0; m_st = 0; m_run = 0;
    end else if (we) begin
      case (addr)
        8'h00: begin
          m_load = wd; m_cnt = wd;
          if (m_en) begin m_run = (m_p != 0 || wd != 0); if (m_run) m_div = 0; end
        end
        8'h04: begin
          v = (m_en && m_per && m_p == 0 && wd == 0) ? m_load : wd;
          m_cnt = v;
          if (m_en) begin m_run = (m_p != 0 || v != 0); if (m_run) m_div = 0; end
        end
        8'h08: begin
          np = wd[15:8];
          chg = wd[1:0] != {m_per, m_en};
          was = m_run;
          if (chg) m_run = 0;
          if (wd[0]) begin
            if (wd[1] && np == 0 && m_cnt == 0) m_cnt = m_load;
            if (np != 0 || m_cnt != 0) m_run = 1;
          end
          if (m_run && (!was || chg || np != m_p)) m_div = 0;
          m_en = wd[0]; m_per = wd[1]; m_ie = wd[2]; m_p = np;
        end
        8'h0C: if (wd[0]) m_st = 0;
        default: ;
      endcase
    end else if (m_run) begin
      if (m_div == m_p) begin
        m_div = 0;
        if (m_cnt == 0) begin
          if (m_per) begin
            m_cnt = m_load;
            if (m_load == 0) begin m_st = 1; if (m_p == 0) m_run = 0; end
          end else begin m_st = 1; m_run = 0; end
        end else begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin m_st = 1; if (!m_per) m_run = 0; end
        end
      end else m_div = m_div + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      logic [31:0] e;
      string tag;
      case (addr)
        8'h00: begin e = m_load; tag = "R1 reload"; end
        8'h04: begin e = m_cnt; tag = "R3 counter"; end
        8'h08: begin e = {16'h0, m_p, 5'h0, m_ie, m_per, m_en}; tag = "R2 control"; end
        8'h0C: begin e = {31'h0, m_st}; tag = "R5 status"; end
        default: begin e = 0; tag = "R1 unused"; end
      endcase
      chk(tag, rd, e);
      chk("R4 irq", {31'h0, irq}, {31'h0, m_st & m_ie});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    we = 1; addr = a; wd = d;
    @(posedge clk); #1;
    we = 0; addr = 8'h04;
  endtask

  task automatic peek(logic [7:0] a, string tag, logic [31:0] exp);
    addr = a; #0.2;
    chk(tag, rd, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    idle(3);
    rst_n = 1; #0.5;
    peek(8'h00, "R11 reload", 0);
    peek(8'h04, "R11 counter", 0);
    peek(8'h08, "R11 control", 0);
    peek(8'h0C, "R11 status", 0);
    chk("R11 irq", {31'h0, irq}, 0);
    addr = 8'h04;

    wr(8'h00, 5);
    peek(8'h04, "R7 counter loaded", 5);
    wr(8'h08, 32'h5);
    idle(12);
    peek(8'h04, "R6 oneshot end", 0);
    peek(8'h0C, "R4 status set", 1);
    chk("R4 irq high", {31'h0, irq}, 1);
    idle(5);
    peek(8'h04, "R6 oneshot hold", 0);
    wr(8'h0C, 0);
    peek(8'h0C, "R5 zero write", 1);
    wr(8'h0C, 1);
    peek(8'h0C, "R5 cleared", 0);
    chk("R5 irq low", {31'h0, irq}, 0);

    wr(8'h08, 32'h307);
    idle(40);
    peek(8'h0C, "R6 periodic expiry", 1);
    wr(8'h00, 0);
    wr(8'h0C, 1);
    idle(6);
    peek(8'h0C, "R9 retrigger P>0", 1);
    wr(8'h08, 32'h7);
    idle(4);
    wr(8'h0C, 1);
    idle(10);
    peek(8'h0C, "R9 P=0 stops", 0);
    peek(8'h04, "R9 counter", 0);

    wr(8'h00, 9);
    idle(3);
    wr(8'h0C, 1);
    wr(8'h00, 0);
    idle(10);
    peek(8'h0C, "R7 quiet stop", 0);
    peek(8'h04, "R7 counter zero", 0);

    wr(8'h00, 7);
    wr(8'h04, 0);
    peek(8'h04, "R8 replaced by reload", 7);
    wr(8'h08, 32'h5);
    wr(8'h0C, 1);
    wr(8'h04, 0);
    idle(10);
    peek(8'h0C, "R8 oneshot quiet stop", 0);
    peek(8'h04, "R8 counter zero", 0);

    wr(8'h04, 50);
    idle(5);
    wr(8'h08, 32'h4);
    addr = 8'h04; #0.2;
    held = rd;
    idle(20);
    peek(8'h04, "R10 stopped holds", held);
    wr(8'h08, 32'h5);
    peek(8'h04, "R10 resumes from count", held);

    wr(8'h10, 32'hDEAD_BEEF);
    peek(8'h10, "R1 unused offset", 0);
    peek(8'h14, "R1 other offset", 0);
    peek(8'h00, "R1 reload untouched", 7);

    wr(8'h08, 32'hFFFF_FFF8);
    peek(8'h08, "R2 control readback", 32'h0000_FF00);
    wr(8'h04, 2);
    wr(8'h08, 32'hFF01);
    idle(200);
    peek(8'h04, "R3 P=255 before step", 2);
    idle(60);
    peek(8'h04, "R3 P=255 after step", 1);
    addr = 8'h04;

    idle(5);
    finish_run();
  end
endmodule